// File: doc/BRIEF.md
# Parallel-Lane Packet Distributor with Start Lane and XOR Check Lane

This block sends a fixed packet of 32-bit words over a one-way, chip-to-chip link that runs without pause. A single serial lane is too slow, so the block deals the packet out across several data lanes. By default there are 30 words on 6 lanes, 5 words per lane. A free-running period timer starts each packet. A separate start lane goes high for a set number of cycles before any word is handed out, which lets the far end find the packet boundary. One more lane carries a check word for each word slot. The check word is the bitwise XOR of the words the data lanes send in that slot. The far end can then find a damaged slot without per-word parity.

The block takes the whole packet as a flat word vector and captures it when a packet starts. It hands words to the lane serializers over a valid/ready interface, one handshake per lane. All lanes, data and check, are offered a slot in the same cycle. A lane's valid stays high with steady data until that lane's ready is seen. After a lane accepts, its valid drops while other lanes are still pending. The next slot is offered only when every lane has accepted the current one. So a slow serializer stalls the whole packet but never reorders it. Ready may be driven at any time and has no effect on a lane that is not valid. If the timer fires while a packet is still in progress, that start is dropped and a sticky overrun flag is set.

Top module: `ld_lane_distributor`

## Requirements
- R1: After reset, `sync_o` is low, every bit of `lane_valid_o` is low and `overrun_o` is low.
- R2: While `run_i` is high, the period timer fires once every PERIOD cycles. The first firing comes on the PERIOD-th clock edge after `run_i` goes high. Holding `run_i` low stops the timer and restarts its count. A firing while the block is idle starts a packet on that edge.
- R3: `sync_o` is high for exactly SYNC_CYCLES cycles, starting the cycle after the start edge. Slot 0 is offered on all lanes in the first cycle after `sync_o` falls. `sync_o` and any lane valid are never high together.
- R4: Packet entry i is `pkt_words_i[i*32 +: 32]`. In slot k, data lane L (0 to NUM_LANES-1) carries entry L*WORDS_PER_LANE+k. Slots go out in ascending order. The words are captured on the start edge, so later changes to `pkt_words_i` do not alter the packet in flight.
- R5: Lane index NUM_LANES is the check lane. Its word in each slot is the bitwise XOR of the data-lane words of that slot.
- R6: All NUM_LANES+1 valids rise together when a slot is offered. A lane's valid and word hold steady until its ready is high. The lane's valid drops on the edge where its ready is seen, unless that edge completes the slot.
- R7: When the last pending lane of a slot accepts, the next slot is offered on all lanes in the following cycle. After slot WORDS_PER_LANE-1 completes, all valids go low and the block is idle.
- R8: A timer firing while a packet is in the start phase or the word phase is ignored and sets `overrun_o`. This includes a firing on the very edge that completes the last slot. On that edge the block goes idle and no new packet starts.
- R9: `overrun_o` stays high once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Enables the period timer |
| pkt_words_i | input | NUM_LANES*WORDS_PER_LANE*32 | Packet buffer, entry i at bits [i*32 +: 32] |
| sync_o | output | 1 | Start-of-packet lane |
| lane_valid_o | output | NUM_LANES+1 | Per-lane word valid; top bit is the check lane |
| lane_ready_i | input | NUM_LANES+1 | Per-lane serializer ready |
| lane_word_o | output | (NUM_LANES+1)*32 | Per-lane word, lane j at bits [j*32 +: 32] |
| overrun_o | output | 1 | Sticky: a timer start arrived while busy |

## Verification
Two events can land on the same clock edge: the timer fires on the edge where the last lane accepts the final slot. The bench provokes this on purpose. It holds every ready low in the last slot until its model timer is one cycle from firing, then raises all readies. The expected result is that `overrun_o` is set and `sync_o` stays low in the next cycle, with the following start handled normally. The same situation also comes up at random when serializers answer slowly. A behavioural model judges every cycle of that traffic.

// File: rtl/ld_pkg.sv
package ld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_SEND = 2'd2
  } ld_state_e;
endpackage

// File: rtl/ld_cycle_timer.sv
module ld_cycle_timer #(
  parameter int unsigned PERIOD = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ld_slot_select.sv
module ld_slot_select #(
  parameter int unsigned NUM_LANES      = 6,
  parameter int unsigned WORDS_PER_LANE = 5,
  parameter int unsigned WORD_W         = 32
) (
  input  logic [NUM_LANES*WORDS_PER_LANE*WORD_W-1:0] snap_i,
  input  logic [$clog2(WORDS_PER_LANE)-1:0]          slot_i,
  output logic [(NUM_LANES+1)*WORD_W-1:0]            lane_words_o
);
  localparam int unsigned NUM_WORDS = NUM_LANES * WORDS_PER_LANE;
  localparam int unsigned SLOT_W    = $clog2(WORDS_PER_LANE);

  function automatic logic [WORD_W-1:0] pick_word(
    input logic [NUM_WORDS*WORD_W-1:0] buf_w,
    input int unsigned                 lane,
    input logic [SLOT_W-1:0]           slot
  );
    logic [WORD_W-1:0] w;
    w = '0;
    for (int unsigned k = 0; k < WORDS_PER_LANE; k++) begin
      if (slot == SLOT_W'(k)) w = buf_w[(lane*WORDS_PER_LANE + k)*WORD_W +: WORD_W];
    end
    return w;
  endfunction

  logic [WORD_W-1:0] chk_w;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_words_o[g*WORD_W +: WORD_W] = pick_word(snap_i, g, slot_i);
  end

  always_comb begin
    chk_w = '0;
    for (int unsigned l = 0; l < NUM_LANES; l++) begin
      chk_w = chk_w ^ lane_words_o[l*WORD_W +: WORD_W];
    end
  end

  assign lane_words_o[NUM_LANES*WORD_W +: WORD_W] = chk_w;
endmodule

// File: rtl/ld_accept_tracker.sv
module ld_accept_tracker #(
  parameter int unsigned NUM_T = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [NUM_T-1:0] ready_i,
  output logic [NUM_T-1:0] valid_o,
  output logic             done_o
);
  logic [NUM_T-1:0] pend_q;

  assign valid_o = pend_q;
  assign done_o  = (|pend_q) && ((pend_q & ~ready_i) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= '0;
    else if (arm_i) pend_q <= '1;
    else            pend_q <= pend_q & ~ready_i;
  end

  for (genvar g = 0; g < NUM_T; g++) begin : g_chk
    // R6
    lane_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o[g] && ready_i[g] && !arm_i) |=> !valid_o[g]);
  end
endmodule

// File: rtl/ld_lane_distributor.sv
module ld_lane_distributor
  import ld_pkg::*;
#(
  parameter int unsigned NUM_LANES      = 6,
  parameter int unsigned WORDS_PER_LANE = 5,
  parameter int unsigned WORD_W         = 32,
  parameter int unsigned PERIOD         = 512,
  parameter int unsigned SYNC_CYCLES    = 4
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       run_i,
  input  logic [NUM_LANES*WORDS_PER_LANE*WORD_W-1:0] pkt_words_i,
  output logic                                       sync_o,
  output logic [NUM_LANES:0]                         lane_valid_o,
  input  logic [NUM_LANES:0]                         lane_ready_i,
  output logic [(NUM_LANES+1)*WORD_W-1:0]            lane_word_o,
  output logic                                       overrun_o
);
  localparam int unsigned NUM_T  = NUM_LANES + 1;
  localparam int unsigned SLOT_W = $clog2(WORDS_PER_LANE);
  localparam int unsigned SC_W   = (SYNC_CYCLES > 1) ? $clog2(SYNC_CYCLES) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WORDS_PER_LANE - 1);
  localparam logic [SC_W-1:0]   LAST_SC   = SC_W'(SYNC_CYCLES - 1);

  ld_state_e state_q;
  logic [SC_W-1:0]   sc_q;
  logic [SLOT_W-1:0] slot_q;
  logic [NUM_LANES*WORDS_PER_LANE*WORD_W-1:0] snap_q;
  logic ovr_q;
  logic tick, done, arm, last_slot, sync_end;

  ld_cycle_timer #(.PERIOD(PERIOD)) timer_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run_i), .tick_o(tick)
  );

  ld_slot_select #(
    .NUM_LANES(NUM_LANES), .WORDS_PER_LANE(WORDS_PER_LANE), .WORD_W(WORD_W)
  ) select_i (
    .snap_i(snap_q), .slot_i(slot_q), .lane_words_o(lane_word_o)
  );

  ld_accept_tracker #(.NUM_T(NUM_T)) track_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm),
    .ready_i(lane_ready_i), .valid_o(lane_valid_o), .done_o(done)
  );

  assign last_slot = (slot_q == LAST_SLOT);
  assign sync_end  = (state_q == ST_SYNC) && (sc_q == LAST_SC);
  assign arm       = sync_end || ((state_q == ST_SEND) && done && !last_slot);
  assign sync_o    = (state_q == ST_SYNC);
  assign overrun_o = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sc_q    <= '0;
      slot_q  <= '0;
      snap_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (tick) begin
          snap_q  <= pkt_words_i;
          sc_q    <= '0;
          state_q <= ST_SYNC;
        end
        ST_SYNC: if (sync_end) begin
          slot_q  <= '0;
          state_q <= ST_SEND;
        end else begin
          sc_q <= sc_q + 1'b1;
        end
        ST_SEND: if (done) begin
          if (last_slot) state_q <= ST_IDLE;
          else           slot_q  <= slot_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ovr_q <= 1'b0;
    else if (tick && state_q != ST_IDLE) ovr_q <= 1'b1;
  end

  // R3
  sync_then_offer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> (&lane_valid_o));
  // R3
  sync_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> (lane_valid_o == '0));
  // R9
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  for (genvar g = 0; g < NUM_T; g++) begin : g_hold
    // R6
    word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_valid_o[g] && !lane_ready_i[g]) |=>
        (lane_valid_o[g] && $stable(lane_word_o[g*WORD_W +: WORD_W])));
  end
endmodule

// File: tb/ld_lane_distributor_tb_top.sv
`timescale 1ns/1ps
module ld_lane_distributor_tb_top;
  localparam int NL = 6;
  localparam int WPL = 5;
  localparam int NW = NL * WPL;
  localparam int NT = NL + 1;
  localparam int P  = 40;
  localparam int SC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [NW*32-1:0] words = '0;
  logic [NT-1:0] ready = '0;
  logic sync;
  logic [NT-1:0] valid;
  logic [NT*32-1:0] lw;
  logic ovr;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  ld_lane_distributor #(
    .NUM_LANES(NL), .WORDS_PER_LANE(WPL), .WORD_W(32), .PERIOD(P), .SYNC_CYCLES(SC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .pkt_words_i(words),
    .sync_o(sync), .lane_valid_o(valid), .lane_ready_i(ready),
    .lane_word_o(lw), .overrun_o(ovr)
  );

  // Behavioural reference model
  int m_state = 0, m_cnt = 0, m_sc = 0, m_slot = 0, m_starts = 0;
  bit [NT-1:0] m_pend = '0;
  bit m_ovr = 0;
  logic [31:0] m_snap [NW];

  always @(posedge clk) begin
    bit tk;
    bit [NT-1:0] rem;
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_sc = 0; m_slot = 0; m_pend = '0; m_ovr = 0;
    end else begin
      tk = run && (m_cnt == P - 1);
      if (tk && m_state != 0) m_ovr = 1;
      case (m_state)
        0: if (tk) begin
          for (int i = 0; i < NW; i++) m_snap[i] = words[i*32 +: 32];
          m_state = 1; m_sc = 0; m_starts++;
        end
        1: if (m_sc == SC - 1) begin
          m_state = 2; m_slot = 0; m_pend = '1;
        end else m_sc++;
        default: begin
          rem = m_pend & ~ready;
          if (rem == '0) begin
            if (m_slot == WPL - 1) begin m_state = 0; m_pend = '0; end
            else begin m_slot++; m_pend = '1; end
          end else m_pend = rem;
        end
      endcase
      m_cnt = (!run || tk) ? 0 : m_cnt + 1;
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  int dut_rises = 0;
  logic prev_sync = 0;

  always @(negedge clk) begin
    logic [31:0] ew, ex;
    if (!done_flag) begin
      chk(sync === (m_state == 1), "R3", "sync", {31'd0, sync}, {31'd0, m_state == 1});
      chk(valid === m_pend, "R6", "lane valid", 32'(valid), 32'(m_pend));
      chk(ovr === m_ovr, "R8", "overrun", {31'd0, ovr}, {31'd0, m_ovr});
      if (m_state == 2) begin
        ex = '0;
        for (int l = 0; l < NL; l++) begin
          ew = m_snap[l*WPL + m_slot];
          ex = ex ^ ew;
          if (m_pend[l]) chk(lw[l*32 +: 32] === ew, "R4", $sformatf("lane %0d word", l), lw[l*32 +: 32], ew);
        end
        if (m_pend[NL]) chk(lw[NL*32 +: 32] === ex, "R5", "check word", lw[NL*32 +: 32], ex);
      end
      if (sync && !prev_sync) dut_rises++;
      prev_sync = sync;
    end
  end

  task automatic step();
    @(negedge clk); #1;
    words = {NW{$urandom()}};
    for (int i = 0; i < NW; i++) words[i*32 +: 32] = $urandom();
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit hit;
    for (int i = 0; i < NW; i++) m_snap[i] = '0;
    repeat (4) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(sync === 1'b0, "R1", "sync after reset", {31'd0, sync}, 32'd0);
    chk(valid === '0, "R1", "valid after reset", 32'(valid), 32'd0);
    chk(ovr === 1'b0, "R1", "overrun after reset", {31'd0, ovr}, 32'd0);

    // Phase: always-ready serializers, R2 R4 R5 R7
    run = 1'b1; ready = '1;
    repeat (300) step();
    // Phase: random ready
    repeat (400) begin step(); ready = NT'($urandom()) | NT'($urandom()); end
    // Phase: timer stopped and restarted, R2
    run = 1'b0; ready = '1;
    repeat (60) step();
    chk(sync === 1'b0 && valid === '0, "R2", "idle with timer stopped", {31'd0, sync}, 32'd0);
    run = 1'b1;
    repeat (200) step();
    // Phase: very slow serializers cause overrun, R8
    repeat (600) begin
      step();
      for (int l = 0; l < NT; l++) ready[l] = ($urandom() % 10) == 0;
    end
    chk(ovr === 1'b1, "R8", "overrun after slow lanes", {31'd0, ovr}, 32'd1);
    // R9 sticky with no traffic
    run = 1'b0; ready = '1;
    repeat (50) step();
    chk(ovr === 1'b1, "R9", "overrun held", {31'd0, ovr}, 32'd1);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    chk(ovr === 1'b0, "R9", "overrun cleared by reset", {31'd0, ovr}, 32'd0);

    // Phase: timer firing on the edge that completes the final slot, R8
    run = 1'b1; hit = 0;
    repeat (400) begin
      step();
      if (!hit && m_state == 2 && m_slot == WPL - 1) begin
        if (m_cnt == P - 1) begin
          chk(ovr === 1'b0, "R8", "overrun before coincidence", {31'd0, ovr}, 32'd0);
          ready = '1; hit = 1;
          step();
          ready = '1;
          chk(ovr === 1'b1, "R8", "overrun on coincident start", {31'd0, ovr}, 32'd1);
          chk(sync === 1'b0, "R8", "no start on coincident edge", {31'd0, sync}, 32'd0);
          chk(valid === '0, "R7", "idle after last slot", 32'(valid), 32'd0);
        end else ready = '0;
      end else ready = '1;
    end
    chk(hit == 1, "R8", "coincidence reached", {31'd0, hit}, 32'd1);

    repeat (5) step();
    // R2 packet starts match the period timer
    chk(dut_rises == m_starts && m_starts > 0, "R2", "packet start count",
        32'(dut_rises), 32'(m_starts));
    finish_run();
  end
endmodule